// File: doc/BRIEF.md
# Parallel-Compare Dictionary Scan Engine

The engine finds every dictionary key that starts at each character offset of a text. The text passes through a window of KEY_LEN character registers. For the character at the head of the window, a small index table gives a first address and a key count. The engine then walks that address range. One shared address drives KEY_LEN column memories, and each column memory holds one character position of every key. All KEY_LEN positions are compared in parallel, so each address costs one three-cycle compare step. When the range is used up, the window moves forward by one character and the lookup repeats. The scan ends when the end mark reaches the head of the window.

Before a scan, the host loads the dictionary and the index table through simple write ports. Keys go in ascending key order, and keys shorter than KEY_LEN are padded with the fill symbol. The host then pulses `start` and streams the text through a valid/ready port, marking the final character with `txt_last`. Every hit comes out as a one-cycle pulse that carries the dictionary address and the text offset. A one-cycle `done` pulse closes the scan.

Top module: `dict_scan_engine`

## Requirements
- R1: After reset, and whenever no scan is running, `busy`, `hit`, `done` and `txt_ready` are all 0.
- R2: A dictionary word is written at `dict_waddr` with `dict_we`, with key character n at bits [16n+15:16n] of `dict_wkey` (n = 0 is the first character). A key is reported at a window position only when all KEY_LEN columns match. A mismatch in any single column, including the last one, gives no hit.
- R3: A key column holding the fill symbol 16'hFFFF matches any window character. Window positions past the end of the text hold the end mark 16'hFFFE, which is matched only by the fill symbol. A key longer than the remaining text is therefore never reported.
- R4: Index entry s, written with `idx_we`, `idx_wsel`, `idx_wtop` and `idx_wcnt`, is selected by the low IDX_W bits of the character at the window head. Every address from top to top+count-1 is compared. The first column is compared too, so a head character that only aliases in its low bits produces no hit.
- R5: Hits come out in ascending text offset, and within one offset in ascending address. `hit_pos` is the zero-based text offset of the window head, and `hit_addr` is the matching dictionary address.
- R6: One compare step takes three clock cycles. Hits at consecutive addresses within one window position are exactly 3 cycles apart, and `hit` is never high in two adjacent cycles.
- R7: An index entry with a count of zero causes no compare steps and no hits at that offset. The window simply shifts.
- R8: `done` is high for exactly one cycle, when the end mark reaches the window head. `busy` is 0 from that cycle on, and no hit follows.
- R9: A text character is taken only in a cycle with `txt_valid` and `txt_ready` both high. Gaps in `txt_valid` do not change the hit list. `txt_ready` is low outside a scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a scan when idle |
| txt_valid | input | 1 | Text character valid |
| txt_char | input | 16 | Text character |
| txt_last | input | 1 | Marks the final text character |
| txt_ready | output | 1 | Engine takes a text character this cycle |
| dict_we | input | 1 | Dictionary word write enable |
| dict_waddr | input | ADDR_W | Dictionary write address |
| dict_wkey | input | KEY_LEN*16 | Padded key, column n at bits [16n+15:16n] |
| idx_we | input | 1 | Index table write enable |
| idx_wsel | input | IDX_W | Index entry selected for the write |
| idx_wtop | input | ADDR_W | First dictionary address of the range |
| idx_wcnt | input | ADDR_W+1 | Number of keys in the range |
| busy | output | 1 | A scan is running |
| hit | output | 1 | One-cycle hit pulse |
| hit_addr | output | ADDR_W | Dictionary address of the hit |
| hit_pos | output | POS_W | Text offset of the hit |
| done | output | 1 | One-cycle end-of-scan pulse |

## Verification
The properties assume that `start` is raised only while the engine is idle, so the ordering tracker restarts once per scan. They also assume that the dictionary and the index table are written only between scans, and that text characters never take the fill or end-mark codes. The bench writes both tables before any scan begins. Its texts use only ASCII capitals. It raises `start` only after the previous `done`, and it drives the text port only when `txt_ready` is high, so that each scan is self-contained.

// File: rtl/dse_pkg.sv
package dse_pkg;

    localparam int CHAR_W = 16;

    typedef logic [CHAR_W-1:0] char_t;

    localparam char_t FILL_SYM = '1;
    localparam char_t END_SYM  = ~char_t'(1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_FILL,
        S_LOOK,
        S_RD,
        S_CMP,
        S_JUDGE,
        S_SHIFT
    } seq_state_e;

    function automatic logic col_hit(char_t key_ch, char_t txt_ch);
        return (key_ch == FILL_SYM) || (key_ch == txt_ch);
    endfunction

endpackage

// File: rtl/dse_window.sv
module dse_window
    import dse_pkg::*;
#(
    parameter int KEY_LEN = 8,
    localparam int LDW    = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clear,
    input  logic                      ld_en,
    input  logic [LDW-1:0]            ld_idx,
    input  char_t                     ld_char,
    input  logic                      sh_en,
    input  char_t                     sh_char,
    output logic [KEY_LEN*CHAR_W-1:0] win_flat
);

    char_t slot_q [KEY_LEN];

    for (genvar i = 0; i < KEY_LEN; i++) begin : g_slot
        char_t next_c;

        if (i == KEY_LEN - 1) begin : g_tail
            assign next_c = sh_char;
        end else begin : g_body
            assign next_c = slot_q[i+1];
        end

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                slot_q[i] <= END_SYM;
            end else if (ld_en && (ld_idx == LDW'(i))) begin
                slot_q[i] <= ld_char;
            end else if (sh_en) begin
                slot_q[i] <= next_c;
            end
        end

        assign win_flat[i*CHAR_W +: CHAR_W] = slot_q[i];
    end

endmodule

// File: rtl/dse_column.sv
module dse_column
    import dse_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  char_t             wchar,
    input  logic [ADDR_W-1:0] raddr,
    input  char_t             txt_ch,
    output logic              match_q
);

    char_t mem [DEPTH];
    char_t rd_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wchar;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q    <= FILL_SYM;
            match_q <= 1'b0;
        end else begin
            rd_q    <= mem[raddr];
            match_q <= col_hit(rd_q, txt_ch);
        end
    end

endmodule

// File: rtl/dse_index.sv
module dse_index #(
    parameter int IDX_W  = 4,
    parameter int ADDR_W = 6,
    localparam int CNT_W   = ADDR_W + 1,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  wsel,
    input  logic [ADDR_W-1:0] wtop,
    input  logic [CNT_W-1:0]  wcnt,
    input  logic [IDX_W-1:0]  rsel,
    output logic [ADDR_W-1:0] rtop,
    output logic [CNT_W-1:0]  rcnt
);

    logic [ADDR_W-1:0] top_q [ENTRIES];
    logic [CNT_W-1:0]  cnt_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                top_q[e] <= '0;
                cnt_q[e] <= '0;
            end else if (we && (wsel == IDX_W'(e))) begin
                top_q[e] <= wtop;
                cnt_q[e] <= wcnt;
            end
        end
    end

    assign rtop = top_q[rsel];
    assign rcnt = cnt_q[rsel];

endmodule

// File: rtl/dse_seq.sv
module dse_seq
    import dse_pkg::*;
#(
    parameter int KEY_LEN = 8,
    parameter int ADDR_W  = 6,
    parameter int POS_W   = 16,
    localparam int CNT_W  = ADDR_W + 1,
    localparam int LDW    = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              txt_valid,
    input  logic              txt_last,
    output logic              txt_ready,
    input  char_t             head_ch,
    input  logic [ADDR_W-1:0] rng_top,
    input  logic [CNT_W-1:0]  rng_cnt,
    input  logic              all_match,
    output logic              win_clear,
    output logic              win_ld_en,
    output logic [LDW-1:0]    win_ld_idx,
    output logic              win_sh_en,
    output logic              win_sh_end,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              hit,
    output logic [ADDR_W-1:0] hit_addr,
    output logic [POS_W-1:0]  hit_pos,
    output logic              done
);

    localparam logic [LDW-1:0] LAST_K = LDW'(KEY_LEN - 1);

    seq_state_e        state_q;
    logic [LDW-1:0]    fill_k_q;
    logic              end_seen_q;
    logic [ADDR_W-1:0] cur_q;
    logic [CNT_W-1:0]  left_q;
    logic [POS_W-1:0]  pos_q;
    logic              take_shift;

    assign take_shift = (state_q == S_SHIFT) && (end_seen_q || txt_valid);

    always_comb begin
        txt_ready  = (state_q == S_FILL) || ((state_q == S_SHIFT) && !end_seen_q);
        win_clear  = (state_q == S_IDLE) && start;
        win_ld_en  = (state_q == S_FILL) && txt_valid;
        win_ld_idx = fill_k_q;
        win_sh_en  = take_shift;
        win_sh_end = end_seen_q;
        rd_addr    = cur_q;
        busy       = (state_q != S_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= S_IDLE;
            fill_k_q   <= '0;
            end_seen_q <= 1'b0;
            cur_q      <= '0;
            left_q     <= '0;
            pos_q      <= '0;
            hit        <= 1'b0;
            hit_addr   <= '0;
            hit_pos    <= '0;
            done       <= 1'b0;
        end else begin
            hit  <= 1'b0;
            done <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        fill_k_q   <= '0;
                        end_seen_q <= 1'b0;
                        pos_q      <= '0;
                        state_q    <= S_FILL;
                    end
                end
                S_FILL: begin
                    if (txt_valid) begin
                        fill_k_q <= fill_k_q + 1'b1;
                        if (txt_last || (fill_k_q == LAST_K)) begin
                            end_seen_q <= txt_last;
                            state_q    <= S_LOOK;
                        end
                    end
                end
                S_LOOK: begin
                    if (head_ch == END_SYM) begin
                        done    <= 1'b1;
                        state_q <= S_IDLE;
                    end else if (rng_cnt == '0) begin
                        state_q <= S_SHIFT;
                    end else begin
                        cur_q   <= rng_top;
                        left_q  <= rng_cnt;
                        state_q <= S_RD;
                    end
                end
                S_RD: begin
                    state_q <= S_CMP;
                end
                S_CMP: begin
                    state_q <= S_JUDGE;
                end
                S_JUDGE: begin
                    hit      <= all_match;
                    hit_addr <= cur_q;
                    hit_pos  <= pos_q;
                    cur_q    <= cur_q + 1'b1;
                    left_q   <= left_q - 1'b1;
                    state_q  <= (left_q == CNT_W'(1)) ? S_SHIFT : S_RD;
                end
                S_SHIFT: begin
                    if (take_shift) begin
                        pos_q <= pos_q + 1'b1;
                        if (!end_seen_q) begin
                            end_seen_q <= txt_last;
                        end
                        state_q <= S_LOOK;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dict_scan_engine.sv
module dict_scan_engine
    import dse_pkg::*;
#(
    parameter int KEY_LEN = 8,
    parameter int ADDR_W  = 6,
    parameter int IDX_W   = 4,
    parameter int POS_W   = 16,
    localparam int CNT_W  = ADDR_W + 1,
    localparam int LDW    = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      txt_valid,
    input  logic [CHAR_W-1:0]         txt_char,
    input  logic                      txt_last,
    output logic                      txt_ready,
    input  logic                      dict_we,
    input  logic [ADDR_W-1:0]         dict_waddr,
    input  logic [KEY_LEN*CHAR_W-1:0] dict_wkey,
    input  logic                      idx_we,
    input  logic [IDX_W-1:0]          idx_wsel,
    input  logic [ADDR_W-1:0]         idx_wtop,
    input  logic [CNT_W-1:0]          idx_wcnt,
    output logic                      busy,
    output logic                      hit,
    output logic [ADDR_W-1:0]         hit_addr,
    output logic [POS_W-1:0]          hit_pos,
    output logic                      done
);

    logic [KEY_LEN*CHAR_W-1:0] win_flat;
    logic [KEY_LEN-1:0]        col_match;
    logic                      win_clear;
    logic                      win_ld_en;
    logic [LDW-1:0]            win_ld_idx;
    logic                      win_sh_en;
    logic                      win_sh_end;
    logic [ADDR_W-1:0]         rd_addr;
    logic [ADDR_W-1:0]         rng_top;
    logic [CNT_W-1:0]          rng_cnt;
    char_t                     head_ch;
    char_t                     sh_char;

    assign head_ch = win_flat[CHAR_W-1:0];
    assign sh_char = win_sh_end ? END_SYM : txt_char;

    dse_window #(.KEY_LEN(KEY_LEN)) win_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (win_clear),
        .ld_en    (win_ld_en),
        .ld_idx   (win_ld_idx),
        .ld_char  (txt_char),
        .sh_en    (win_sh_en),
        .sh_char  (sh_char),
        .win_flat (win_flat)
    );

    dse_index #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) idx_i (
        .clk  (clk),
        .rst  (rst),
        .we   (idx_we),
        .wsel (idx_wsel),
        .wtop (idx_wtop),
        .wcnt (idx_wcnt),
        .rsel (head_ch[IDX_W-1:0]),
        .rtop (rng_top),
        .rcnt (rng_cnt)
    );

    for (genvar n = 0; n < KEY_LEN; n++) begin : g_col
        dse_column #(.ADDR_W(ADDR_W)) col_i (
            .clk     (clk),
            .rst     (rst),
            .we      (dict_we),
            .waddr   (dict_waddr),
            .wchar   (dict_wkey[n*CHAR_W +: CHAR_W]),
            .raddr   (rd_addr),
            .txt_ch  (win_flat[n*CHAR_W +: CHAR_W]),
            .match_q (col_match[n])
        );
    end

    dse_seq #(.KEY_LEN(KEY_LEN), .ADDR_W(ADDR_W), .POS_W(POS_W)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .txt_valid  (txt_valid),
        .txt_last   (txt_last),
        .txt_ready  (txt_ready),
        .head_ch    (head_ch),
        .rng_top    (rng_top),
        .rng_cnt    (rng_cnt),
        .all_match  (&col_match),
        .win_clear  (win_clear),
        .win_ld_en  (win_ld_en),
        .win_ld_idx (win_ld_idx),
        .win_sh_en  (win_sh_en),
        .win_sh_end (win_sh_end),
        .rd_addr    (rd_addr),
        .busy       (busy),
        .hit        (hit),
        .hit_addr   (hit_addr),
        .hit_pos    (hit_pos),
        .done       (done)
    );

endmodule

// File: rtl/dse_checker.sv
module dse_checker #(
    parameter int POS_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             txt_ready,
    input logic             hit,
    input logic [POS_W-1:0] hit_pos,
    input logic             done
);

    logic [POS_W-1:0] last_pos_q;

    always_ff @(posedge clk) begin
        if (rst || (start && !busy)) begin
            last_pos_q <= '0;
        end else if (hit) begin
            last_pos_q <= hit_pos;
        end
    end

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !hit));

    a_r6_hit_gap1: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit);

    a_r6_hit_gap2: assert property (@(posedge clk) disable iff (rst)
        hit |=> ##1 !hit);

    a_r9_ready_in_scan: assert property (@(posedge clk) disable iff (rst)
        txt_ready |-> busy);

    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !hit);

    a_r5_pos_order: assert property (@(posedge clk) disable iff (rst)
        hit |-> (hit_pos >= last_pos_q));

endmodule

bind dict_scan_engine dse_checker #(.POS_W(POS_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .txt_ready (txt_ready),
    .hit       (hit),
    .hit_pos   (hit_pos),
    .done      (done)
);

// File: tb/dict_scan_engine_tb_top.sv
`timescale 1ns/1ps
module dict_scan_engine_tb_top;

    localparam int KL = 8;
    localparam int AW = 6;
    localparam int IW = 4;
    localparam int PW = 16;
    localparam int NKEYS = 11;
    localparam logic [15:0] FILLC = 16'hFFFF;
    localparam logic [15:0] ENDC  = 16'hFFFE;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic            txt_valid = 1'b0;
    logic [15:0]     txt_char = '0;
    logic            txt_last = 1'b0;
    logic            txt_ready;
    logic            dict_we = 1'b0;
    logic [AW-1:0]   dict_waddr = '0;
    logic [KL*16-1:0] dict_wkey = '0;
    logic            idx_we = 1'b0;
    logic [IW-1:0]   idx_wsel = '0;
    logic [AW-1:0]   idx_wtop = '0;
    logic [AW:0]     idx_wcnt = '0;
    logic            busy;
    logic            hit;
    logic [AW-1:0]   hit_addr;
    logic [PW-1:0]   hit_pos;
    logic            done;

    always #4 clk = ~clk;

    dict_scan_engine #(.KEY_LEN(KL), .ADDR_W(AW), .IDX_W(IW), .POS_W(PW)) dut_i (
        .clk(clk), .rst(rst), .start(start),
        .txt_valid(txt_valid), .txt_char(txt_char), .txt_last(txt_last),
        .txt_ready(txt_ready),
        .dict_we(dict_we), .dict_waddr(dict_waddr), .dict_wkey(dict_wkey),
        .idx_we(idx_we), .idx_wsel(idx_wsel), .idx_wtop(idx_wtop), .idx_wcnt(idx_wcnt),
        .busy(busy), .hit(hit), .hit_addr(hit_addr), .hit_pos(hit_pos), .done(done)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [15:0] key_tab [NKEYS][KL];
    int          ix_top [16];
    int          ix_cnt [16];
    logic [15:0] txt_buf [32];
    int          txt_len;

    int exp_addr [64];
    int exp_pos  [64];
    int exp_n;
    int got_addr [64];
    int got_pos  [64];
    int got_cyc  [64];
    int got_n;
    int done_n;
    int done_wide;
    int cyc = 0;
    bit prev_done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (hit && got_n < 64) begin
            got_addr[got_n] = int'(hit_addr);
            got_pos[got_n]  = int'(hit_pos);
            got_cyc[got_n]  = cyc;
            got_n++;
        end
        if (done) done_n++;
        if (done && prev_done) done_wide++;
        prev_done = done;
    end

    function automatic void set_key(input int a, input string s);
        for (int n = 0; n < KL; n++) begin
            key_tab[a][n] = (n < s.len()) ? {8'h00, s[n]} : FILLC;
        end
    endfunction

    task automatic load_tables();
        set_key(0, "A");
        set_key(1, "AB");
        set_key(2, "ABC");
        set_key(3, "ABCDEFGH");
        set_key(4, "ABCDEFGX");
        set_key(5, "ABD");
        set_key(6, "AC");
        set_key(7, "B");
        set_key(8, "BCA");
        set_key(9, "BCAB");
        set_key(10, "C");
        for (int e = 0; e < 16; e++) begin
            ix_top[e] = 0;
            ix_cnt[e] = 0;
        end
        ix_top[1] = 0;  ix_cnt[1] = 7;
        ix_top[2] = 7;  ix_cnt[2] = 3;
        ix_top[3] = 10; ix_cnt[3] = 1;
        for (int a = 0; a < NKEYS; a++) begin
            @(negedge clk);
            dict_we    = 1'b1;
            dict_waddr = AW'(a);
            for (int n = 0; n < KL; n++) dict_wkey[n*16 +: 16] = key_tab[a][n];
        end
        @(negedge clk);
        dict_we = 1'b0;
        for (int e = 1; e <= 3; e++) begin
            idx_we   = 1'b1;
            idx_wsel = IW'(e);
            idx_wtop = AW'(ix_top[e]);
            idx_wcnt = (AW+1)'(ix_cnt[e]);
            @(negedge clk);
        end
        idx_we = 1'b0;
    endtask

    function automatic void build_expect();
        exp_n = 0;
        for (int p = 0; p < txt_len; p++) begin
            int sel = int'(txt_buf[p][3:0]);
            for (int a = ix_top[sel]; a < ix_top[sel] + ix_cnt[sel]; a++) begin
                bit ok = 1'b1;
                for (int n = 0; n < KL; n++) begin
                    logic [15:0] t = (p + n < txt_len) ? txt_buf[p+n] : ENDC;
                    if (!(key_tab[a][n] == FILLC || key_tab[a][n] == t)) ok = 1'b0;
                end
                if (ok) begin
                    exp_addr[exp_n] = a;
                    exp_pos[exp_n]  = p;
                    exp_n++;
                end
            end
        end
    endfunction

    task automatic run_scan(input string s, input bit gaps, input string req);
        int i = 0;
        int k = 0;
        int d0;
        txt_len = s.len();
        for (int j = 0; j < txt_len; j++) txt_buf[j] = {8'h00, s[j]};
        build_expect();
        got_n = 0;
        d0 = done_n;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (i < txt_len) begin
            @(negedge clk);
            k++;
            if (gaps && (k % 3 == 0)) begin
                txt_valid = 1'b0;
            end else if (txt_ready) begin
                txt_valid = 1'b1;
                txt_char  = txt_buf[i];
                txt_last  = (i == txt_len - 1);
                i++;
            end else begin
                txt_valid = 1'b0;
            end
        end
        @(negedge clk);
        txt_valid = 1'b0;
        txt_last  = 1'b0;
        for (int w = 0; w < 5000 && done_n == d0; w++) @(negedge clk);
        chk(done_n == d0 + 1, req, "done pulse count", done_n - d0, 1);
        repeat (4) @(negedge clk);
        chk(got_n == exp_n, req, "hit count", got_n, exp_n);
        for (int h = 0; h < exp_n && h < got_n; h++) begin
            chk(got_addr[h] == exp_addr[h], req, $sformatf("hit %0d addr", h),
                got_addr[h], exp_addr[h]);
            chk(got_pos[h] == exp_pos[h], req, $sformatf("hit %0d pos", h),
                got_pos[h], exp_pos[h]);
        end
        chk(busy == 1'b0, "R8", "busy after done", int'(busy), 0);
        chk(txt_ready == 1'b0, "R9", "ready after done", int'(txt_ready), 0);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1", "busy at reset", int'(busy), 0);
        chk(hit == 1'b0, "R1", "hit at reset", int'(hit), 0);
        chk(done == 1'b0, "R1", "done at reset", int'(done), 0);
        chk(txt_ready == 1'b0, "R1", "ready at reset", int'(txt_ready), 0);
    endtask

    task automatic t_full_key();
        run_scan("ABCDEFGH", 1'b0, "R2");
        chk(exp_n == 6, "R2", "model hit total", exp_n, 6);
        chk(got_n > 3 && got_addr[3] == 3, "R2", "full key at 3, last-col key 4 absent",
            (got_n > 3) ? got_addr[3] : -1, 3);
        chk(got_n > 1 && (got_cyc[1] - got_cyc[0]) == 3, "R6", "compare step spacing",
            (got_n > 1) ? got_cyc[1] - got_cyc[0] : -1, 3);
        chk(done_wide == 0, "R8", "done wider than one cycle", done_wide, 0);
    endtask

    task automatic t_alias_stall();
        run_scan("BCABQ", 1'b1, "R9");
        chk(got_n == 7, "R4", "aliased head Q gives no hit", got_n, 7);
        chk(got_n > 6 && got_pos[6] == 3, "R5", "last hit offset",
            (got_n > 6) ? got_pos[6] : -1, 3);
    endtask

    task automatic t_zero_count();
        run_scan("DDD", 1'b0, "R7");
        chk(got_n == 0, "R7", "no hits for empty ranges", got_n, 0);
    endtask

    task automatic t_short_text();
        run_scan("AB", 1'b0, "R3");
        chk(got_n == 3, "R3", "keys past end mark rejected", got_n, 3);
        chk(got_n > 1 && got_addr[1] == 1, "R3", "padded key AB matches",
            (got_n > 1) ? got_addr[1] : -1, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        load_tables();
        t_full_key();
        t_alias_stall();
        t_zero_count();
        t_short_text();
        t_full_key();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule